// File: doc/BRIEF.md
# Integrate-and-Dump Third-Order Integrator Front End

This block is the integrating half of a third-order cascaded integrator-comb decimator for a one-bit sigma-delta stream. One stream bit is consumed on every clock. A first accumulator counts the ones it sees. A second accumulator integrates the first, and a third integrates the second. At the end of each decimation period of R bits, the third accumulator is captured into the output word. On that same edge it is dumped: its own feedback is replaced by zero, so it restarts from the current value of the second accumulator. Because of this dump, the captured word is already the third-stage sum over one period, and the first comb (difference) stage is not needed. The two remaining comb stages are applied downstream, modulo the accumulator width.

The period is 1024 or 256 bits, chosen by `ratio_sel`. The choice is sampled only at a period boundary. A period controller sequences the block through three named states:
- `ST_LOAD` lasts one cycle after reset. It samples the ratio and consumes no bit.
- `ST_INTEG` accumulates.
- `ST_DUMP` is the last bit of a period. It captures, dumps and samples the ratio again.

The transitions are:
- LOAD→INTEG, unconditionally.
- INTEG→DUMP, when the counter reaches R−2.
- INTEG→INTEG, otherwise.
- DUMP→INTEG, always.

All accumulators keep the full width for the long ratio and wrap. With the short ratio, only the low bits of the output are significant and the upper bits are forced to zero.

Top module: `sinc3_dump_integrator`

## Requirements
- R1: While `rst_n` is low, `sample_ready` is 0 and `sample_word` is 0. The first rising edge after reset is the load edge: it samples `ratio_sel` and consumes no stream bit.
- R2: On every consuming edge, the first accumulator adds `bit_in` (a count of ones). The second adds the old first accumulator, and the third adds the old second accumulator. All three are 30 bits wide and wrap modulo 2^30.
- R3: `sample_ready` is a one-cycle pulse that follows the last of every R consuming edges. `ratio_sel`=1 selects R=1024 and `ratio_sel`=0 selects R=256.
- R4: On the last edge of a period, `sample_word` takes the old third accumulator, and the third accumulator loads the old second accumulator plus zero. Each word is therefore the sum of the second accumulator's values over the period's R edges.
- R5: For a period run at R=256, bits 29..24 of the captured word are zero, and bits 23..0 hold the R4 sum modulo 2^24.
- R6: `ratio_sel` is sampled only on the load edge and on the last edge of each period. A change at any other edge has no effect on the current period's length. A change presented at a last edge sets the length of the next period.
- R7: `sample_word` holds its value on every edge other than a period's last edge.
- R8: Sums that exceed 2^30, such as an all-ones input at R=1024, wrap without saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Sigma-delta stream bit, one per clock |
| ratio_sel | input | 1 | Decimation ratio: 1 = 1024, 0 = 256 |
| sample_ready | output | 1 | One-cycle strobe: a new word is available |
| sample_word | output | 30 | Captured third-stage sum of the last period |

## Verification
The dump of the third accumulator and a change of decimation ratio can land on the same edge. At that edge, the old ratio must still govern the output masking, and the new ratio must govern only the following period. The bench provokes this by flipping `ratio_sel` exactly in the cycle whose edge closes a period. It also flips the ratio at random mid-period cycles, which must have no effect. Each result is judged through the strobe timing and the word value, both predicted by a bench model of the three accumulators.

// File: rtl/sinc3_dump_pkg.sv
package sinc3_dump_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DUMP  = 2'd2
    } phase_e;

    localparam logic RATIO_SHORT = 1'b0;
    localparam logic RATIO_LONG  = 1'b1;

endpackage

// File: rtl/sinc3_period_ctl.sv
module sinc3_period_ctl
    import sinc3_dump_pkg::*;
#(
    parameter int LOG2_LONG  = 10,
    parameter int LOG2_SHORT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ratio_sel,
    output logic run,
    output logic dump,
    output logic ratio_q,
    output logic ready
);
    localparam int CNT_W = LOG2_LONG;
    localparam logic [CNT_W-1:0] LONG_PENULT  = CNT_W'((1 << LOG2_LONG) - 2);
    localparam logic [CNT_W-1:0] SHORT_PENULT = CNT_W'((1 << LOG2_SHORT) - 2);
    localparam logic [CNT_W-1:0] LONG_LAST    = CNT_W'((1 << LOG2_LONG) - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST   = CNT_W'((1 << LOG2_SHORT) - 1);

    phase_e           state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] penult;
    logic [CNT_W-1:0] last_idx;

    assign penult   = (ratio_q == RATIO_LONG) ? LONG_PENULT : SHORT_PENULT;
    assign last_idx = (ratio_q == RATIO_LONG) ? LONG_LAST : SHORT_LAST;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:  state_nx = ST_INTEG;
            ST_INTEG: state_nx = (cnt == penult) ? ST_DUMP : ST_INTEG;
            ST_DUMP:  state_nx = ST_INTEG;
            default:  state_nx = ST_LOAD;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        run  = 1'b0;
        dump = 1'b0;
        unique case (state)
            ST_LOAD:  begin run = 1'b0; dump = 1'b0; end
            ST_INTEG: begin run = 1'b1; dump = 1'b0; end
            ST_DUMP:  begin run = 1'b1; dump = 1'b1; end
            default:  begin run = 1'b0; dump = 1'b0; end
        endcase
    end

    // period counter, ratio sample point, strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ratio_q <= RATIO_LONG;
            ready   <= 1'b0;
        end else begin
            ready <= dump;
            if (!run) begin
                cnt     <= '0;
                ratio_q <= ratio_sel;
            end else if (dump) begin
                cnt     <= '0;
                ratio_q <= ratio_sel;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_idx); // R3
    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEG) |=> $stable(ratio_q)); // R6

endmodule

// File: rtl/sinc3_acc_stage.sv
module sinc3_acc_stage #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         dump,
    input  logic [W-1:0] addend,
    output logic [W-1:0] acc
);
    logic [W-1:0] feedback;

    assign feedback = dump ? '0 : acc;

    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (run) acc <= feedback + addend;
    end

endmodule

// File: rtl/sinc3_integ_chain.sv
module sinc3_integ_chain #(
    parameter int ORDER = 3,
    parameter int W     = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    dump,
    input  logic                    bit_in,
    output logic [ORDER-1:0][W-1:0] acc_bus
);
    logic [ORDER-1:0][W-1:0] addend_bus;
    logic [ORDER-1:0]        dump_bus;

    for (genvar i = 0; i < ORDER; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign addend_bus[i] = {{(W-1){1'b0}}, bit_in};
        end else begin : g_body
            assign addend_bus[i] = acc_bus[i-1];
        end
        if (i == ORDER - 1) begin : g_dumped
            assign dump_bus[i] = dump;
        end else begin : g_free
            assign dump_bus[i] = 1'b0;
        end
        sinc3_acc_stage #(.W(W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .dump   (dump_bus[i]),
            .addend (addend_bus[i]),
            .acc    (acc_bus[i])
        );
    end

endmodule

// File: rtl/sinc3_dump_integrator.sv
module sinc3_dump_integrator
    import sinc3_dump_pkg::*;
#(
    parameter int LOG2_R_LONG  = 10,
    parameter int LOG2_R_SHORT = 8,
    parameter int ORDER        = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_in,
    input  logic                          ratio_sel,
    output logic                          sample_ready,
    output logic [ORDER*LOG2_R_LONG-1:0]  sample_word
);
    localparam int ACC_W   = ORDER * LOG2_R_LONG;
    localparam int SHORT_W = ORDER * LOG2_R_SHORT;
    localparam logic [ACC_W-1:0] SHORT_MASK =
        {{(ACC_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    logic                        run, dump, ratio_q;
    logic [ORDER-1:0][ACC_W-1:0] acc_bus;
    logic [ACC_W-1:0]            first_acc, prev_acc, last_acc;
    logic [ACC_W-1:0]            out_mask;

    sinc3_period_ctl #(
        .LOG2_LONG  (LOG2_R_LONG),
        .LOG2_SHORT (LOG2_R_SHORT)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .run       (run),
        .dump      (dump),
        .ratio_q   (ratio_q),
        .ready     (sample_ready)
    );

    sinc3_integ_chain #(
        .ORDER (ORDER),
        .W     (ACC_W)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .dump    (dump),
        .bit_in  (bit_in),
        .acc_bus (acc_bus)
    );

    assign first_acc = acc_bus[0];
    assign prev_acc  = acc_bus[ORDER-2];
    assign last_acc  = acc_bus[ORDER-1];
    assign out_mask  = (ratio_q == RATIO_LONG) ? '1 : SHORT_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n)    sample_word <= '0;
        else if (dump) sample_word <= last_acc & out_mask;
    end

    AST_ACC1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (first_acc - $past(first_acc)) <= ACC_W'(1)); // R2
    AST_DUMP_LOADS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> last_acc == $past(prev_acc)); // R4
    AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> sample_word == ($past(last_acc) & $past(out_mask))); // R4
    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dump && ratio_q == RATIO_SHORT) |=> sample_word[ACC_W-1:SHORT_W] == '0); // R5
    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(sample_word)); // R7

endmodule

// File: tb/sinc3_dump_integrator_test.sv
module sinc3_dump_integrator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        ratio_sel = 1'b1;
    logic        sample_ready;
    logic [29:0] sample_word;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    // bench model of the block's visible behaviour
    bit          m_load;
    int          m_cnt;
    bit          m_ratio;
    logic [29:0] c1, c2, p3;
    bit          e_ready;
    logic [29:0] e_word;

    always #2 clk = ~clk; // 250 MHz

    sinc3_dump_integrator uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .ratio_sel    (ratio_sel),
        .sample_ready (sample_ready),
        .sample_word  (sample_word)
    );

    function automatic int period_len(input bit r);
        return r ? 1024 : 256;
    endfunction

    function automatic logic [29:0] word_mask(input bit r);
        return r ? 30'h3FFF_FFFF : 30'h00FF_FFFF;
    endfunction

    task automatic check(input string req, input logic [29:0] act, input logic [29:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_load = 1'b1; m_cnt = 0; m_ratio = 1'b1;
        c1 = '0; c2 = '0; p3 = '0; e_ready = 1'b0; e_word = '0;
    endtask

    task automatic model_edge(input bit b, input bit r);
        if (m_load) begin
            m_ratio = r; m_load = 1'b0; m_cnt = 0; e_ready = 1'b0;
        end else begin
            if (m_cnt == period_len(m_ratio) - 1) begin
                e_ready = 1'b1;
                e_word  = p3 & word_mask(m_ratio);
                p3      = c2;
                m_cnt   = 0;
                m_ratio = r;
            end else begin
                e_ready = 1'b0;
                p3      = p3 + c2;
                m_cnt++;
            end
            c2 = c2 + c1;
            c1 = c1 + 30'(b);
        end
    endtask

    // called at a falling edge: drive, predict, then judge after the next rise
    task automatic cycle(input bit b, input bit r);
        bit_in    = b;
        ratio_sel = r;
        model_edge(b, r);
        @(negedge clk);
        check("R3", {29'b0, sample_ready}, {29'b0, e_ready});
        check(e_ready ? tag : "R7", sample_word, e_word);
    endtask

    function automatic bit next_is_last();
        return !m_load && (m_cnt == period_len(m_ratio) - 1);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {29'b0, sample_ready}, 30'd0);
        check("R1", sample_word, 30'd0);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1/R2: load edge ignores the bit; a lone one then zeros
        tag = "R2";
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b1);
        for (int i = 0; i < 2100; i++) cycle(1'b0, 1'b1);

        // R4: random stream, long ratio
        tag = "R4";
        for (int i = 0; i < 3072; i++) cycle(1'($urandom), 1'b1);

        // R8: all ones forces wrap of the 30-bit sums
        tag = "R8";
        for (int i = 0; i < 5120; i++) cycle(1'b1, 1'b1);

        // R5: short ratio, random stream
        tag = "R5";
        for (int i = 0; i < 2600; i++) cycle(1'($urandom), 1'b0);

        // R6: ratio wiggled at random cycles, mostly mid-period
        tag = "R6";
        begin
            bit r = 1'b0;
            for (int i = 0; i < 6000; i++) begin
                if (($urandom % 64) == 0) r = ~r;
                cycle(1'($urandom), r);
            end
        end

        // R6: ratio flipped exactly on the edge that closes each period
        for (int i = 0; i < 4200; i++) begin
            bit r = next_is_last() ? ~m_ratio : m_ratio;
            cycle(1'($urandom), r);
        end

        // R1: reset in mid-run, then resume at the short ratio
        tag = "R1";
        do_reset();
        tag = "R5";
        for (int i = 0; i < 1100; i++) cycle(1'($urandom), 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(4 * 120000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule